// File: doc/BRIEF.md
# Write-Once Mode Control Register

This block is an 8-bit control register on a simple single-address bus. A write strobe, an address and write data update it, and a read-data port always shows its contents. The register sets how a small controller is clocked and run. It selects a clock divider and which oscillator type is used. It also holds stop controls for the external and ring oscillators, a stack-page select and a processor-mode field. Every field also appears on its own output pin.

Three bits are protected against runaway software: the oscillation-type bit and the two processor-mode bits. After each reset they accept exactly one plain write. Any write that reaches the register sets a per-reset lock, and from then on those bits hold their value until the next reset.

A bit-operation strobe marks a write that comes from a single-bit set or clear (read-modify-write) instruction. Such a write updates only the unprotected bits. It leaves the protected bits as they are and closes the lock. A set or clear aimed at any ordinary bit therefore freezes the protected bits at their reset values.

Top module: `mode_ctl_reg`

## Requirements
- R1: Reset (rst_n low, asynchronous) sets the register to 0x80 and clears the lock, so rd_data reads 0x80 in the first cycle after reset.
- R2: Bit map: [7:6] drive clk_div_sel, bit 5 drives osc_rc (0 ceramic, 1 RC), bit 4 drives xosc_stop (1 stops), bit 3 drives rosc_stop (1 stops), bit 2 drives stack_page, and [1:0] drive proc_mode (00 single-chip). Each output equals its bits at all times.
- R3: A write that hits the register (wr_en high and addr equal to REG_ADDR) loads bits 7, 6, 4, 3 and 2 from wr_data on the next clock edge, on every write, plain or bit-operation.
- R4: The first plain write (bit_op low) that hits the register after reset loads bits 5, 1 and 0 from wr_data. Every later write leaves those three bits unchanged until reset.
- R5: A write with bit_op high never changes bits 5, 1 and 0 and sets the lock, so no later plain write can change them before reset.
- R6: A cycle with wr_en low, or with addr not equal to REG_ADDR, changes no bit and does not set the lock.
- R7: A reset after the lock is set makes bits 5, 1 and 0 writable once again.
- R8: rd_data returns all 8 current register bits in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Bus address |
| wr_data | input | 8 | Write data |
| bit_op | input | 1 | Marks the write as a single-bit set/clear |
| rd_data | output | 8 | Current register contents |
| clk_div_sel | output | 2 | Clock divider select |
| osc_rc | output | 1 | Oscillation type, 1 = RC |
| xosc_stop | output | 1 | External oscillator stop |
| rosc_stop | output | 1 | Ring oscillator stop |
| stack_page | output | 1 | Stack page select |
| proc_mode | output | 2 | Processor mode |

## Verification
The bench writes the protected bits a second time after the first write has locked them. A design that keeps reloading them would show the new value. It issues a bit-operation write whose data flips the protected bits. A design that treats it as a plain write would take those bits, and a design that does not lock on it would let the following plain write through. It also issues writes to a wrong address and with the strobe low, which must leave both the bits and the lock alone. Finally it resets after locking, to catch a lock that survives reset.

// File: rtl/mode_ctl_pkg.sv
package mode_ctl_pkg;

    localparam int REG_W = 8;

    typedef struct packed {
        logic [1:0] div_sel;
        logic       osc_rc;
        logic       xosc_stop;
        logic       rosc_stop;
        logic       stack_page;
        logic [1:0] proc_mode;
    } mode_reg_t;

    // bit positions guarded by the write-once lock
    localparam logic [REG_W-1:0] GUARD_MASK = 8'b0010_0011;

endpackage

// File: rtl/mode_ctl_decode.sv
module mode_ctl_decode #(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h2C
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    always_comb begin
        hit = wr_en && (addr == REG_ADDR);
    end
endmodule

// File: rtl/mode_ctl_lock.sv
module mode_ctl_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic bit_op,
    output logic lock_q,
    output logic guard_load
);
    logic lock_d;

    always_comb begin
        guard_load = hit && !lock_q && !bit_op;
        lock_d     = lock_q || hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= lock_d;
    end
endmodule

// File: rtl/mode_ctl_fields.sv
module mode_ctl_fields
    import mode_ctl_pkg::*;
(
    input  mode_reg_t  reg_q,
    output logic [1:0] clk_div_sel,
    output logic       osc_rc,
    output logic       xosc_stop,
    output logic       rosc_stop,
    output logic       stack_page,
    output logic [1:0] proc_mode
);
    always_comb begin
        clk_div_sel = reg_q.div_sel;
        osc_rc      = reg_q.osc_rc;
        xosc_stop   = reg_q.xosc_stop;
        rosc_stop   = reg_q.rosc_stop;
        stack_page  = reg_q.stack_page;
        proc_mode   = reg_q.proc_mode;
    end
endmodule

// File: rtl/mode_ctl_reg.sv
module mode_ctl_reg
    import mode_ctl_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h2C,
    parameter logic [REG_W-1:0]  RESET_VAL = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              bit_op,
    output logic [REG_W-1:0]  rd_data,
    output logic [1:0]        clk_div_sel,
    output logic              osc_rc,
    output logic              xosc_stop,
    output logic              rosc_stop,
    output logic              stack_page,
    output logic [1:0]        proc_mode
);
    localparam logic [REG_W-1:0] FREE_MASK = ~GUARD_MASK;

    logic      hit;
    logic      lock_q;
    logic      guard_load;
    mode_reg_t reg_d, reg_q;

    mode_ctl_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .hit   (hit)
    );

    mode_ctl_lock u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .bit_op     (bit_op),
        .lock_q     (lock_q),
        .guard_load (guard_load)
    );

    always_comb begin
        logic [REG_W-1:0] cur, nxt;
        cur = reg_q;
        nxt = cur;
        for (int i = 0; i < REG_W; i++) begin
            if (FREE_MASK[i] && hit)        nxt[i] = wr_data[i];
            if (GUARD_MASK[i] && guard_load) nxt[i] = wr_data[i];
        end
        reg_d = mode_reg_t'(nxt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= mode_reg_t'(RESET_VAL);
        else        reg_q <= reg_d;
    end

    assign rd_data = reg_q;

    mode_ctl_fields u_fields (
        .reg_q       (reg_q),
        .clk_div_sel (clk_div_sel),
        .osc_rc      (osc_rc),
        .xosc_stop   (xosc_stop),
        .rosc_stop   (rosc_stop),
        .stack_page  (stack_page),
        .proc_mode   (proc_mode)
    );
endmodule

// File: rtl/mode_ctl_reg_chk.sv
module mode_ctl_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hit,
    input logic       bit_op,
    input logic       lock_q,
    input logic [7:0] rd_data,
    input logic [1:0] clk_div_sel,
    input logic       osc_rc,
    input logic       xosc_stop,
    input logic       rosc_stop,
    input logic       stack_page,
    input logic [1:0] proc_mode
);
    a_r1_reset_value: assert property (@(posedge clk)
        $rose(rst_n) |-> (rd_data == 8'h80 && !lock_q));

    a_r2_field_map: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data == {clk_div_sel, osc_rc, xosc_stop, rosc_stop, stack_page, proc_mode});

    a_r4_locked_holds: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable({rd_data[5], rd_data[1:0]}));

    a_r5_bitop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bit_op) |=> ($stable({rd_data[5], rd_data[1:0]}) && lock_q));

    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> ($stable(rd_data) && lock_q == $past(lock_q)));
endmodule

bind mode_ctl_reg mode_ctl_reg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit         (hit),
    .bit_op      (bit_op),
    .lock_q      (lock_q),
    .rd_data     (rd_data),
    .clk_div_sel (clk_div_sel),
    .osc_rc      (osc_rc),
    .xosc_stop   (xosc_stop),
    .rosc_stop   (rosc_stop),
    .stack_page  (stack_page),
    .proc_mode   (proc_mode)
);

// File: tb/mode_ctl_reg_test.sv
`timescale 1ns/1ps
module mode_ctl_reg_test;
    localparam logic [7:0] ADDR  = 8'h2C;
    localparam logic [7:0] GUARD = 8'h23;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic       bit_op = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] clk_div_sel, proc_mode;
    logic       osc_rc, xosc_stop, rosc_stop, stack_page;

    int checks = 0;
    int errors = 0;
    logic [7:0] model;
    logic       mlock;

    always #2 clk = ~clk;

    mode_ctl_reg uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .bit_op(bit_op), .rd_data(rd_data),
        .clk_div_sel(clk_div_sel), .osc_rc(osc_rc), .xosc_stop(xosc_stop),
        .rosc_stop(rosc_stop), .stack_page(stack_page), .proc_mode(proc_mode)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model = 8'h80;
        mlock = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d,
                             input logic en, input logic bop);
        @(negedge clk);
        wr_en = en; addr = a; wr_data = d; bit_op = bop;
        @(negedge clk);
        wr_en = 1'b0; bit_op = 1'b0;
        if (en && a == ADDR) begin
            model = (model & GUARD) | (d & ~GUARD);
            if (!mlock && !bop) model = (model & ~GUARD) | (d & GUARD);
            mlock = 1'b1;
        end
    endtask

    task automatic check_fields(input string req);
        check(req, {6'b0, clk_div_sel}, {6'b0, model[7:6]});
        check(req, {7'b0, osc_rc},      {7'b0, model[5]});
        check(req, {7'b0, xosc_stop},   {7'b0, model[4]});
        check(req, {7'b0, rosc_stop},   {7'b0, model[3]});
        check(req, {7'b0, stack_page},  {7'b0, model[2]});
        check(req, {6'b0, proc_mode},   {6'b0, model[1:0]});
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset value", rd_data, 8'h80);
        check_fields("R2 reset fields");
    endtask

    task automatic t_first_write();
        bus_write(ADDR, 8'h3F, 1'b1, 1'b0);
        check("R4 first write loads guarded", rd_data, 8'h3F);
        check_fields("R2 fields after write");
        bus_write(ADDR, 8'hC0, 1'b1, 1'b0);
        check("R4 second write ignored on guarded, R3 free bits load", rd_data, 8'hE3);
        check_fields("R2 fields mixed");
        bus_write(ADDR, 8'h1C, 1'b1, 1'b1);
        check("R3 bit-op updates free bits", rd_data, 8'h3F);
        check("R8 readback matches model", rd_data, model);
    endtask

    task automatic t_miss();
        do_reset();
        bus_write(8'h2D, 8'h5F, 1'b1, 1'b0);
        check("R6 wrong address ignored", rd_data, 8'h80);
        bus_write(ADDR, 8'h5F, 1'b0, 1'b0);
        check("R6 strobe low ignored", rd_data, 8'h80);
        bus_write(ADDR, 8'h21, 1'b1, 1'b0);
        check("R6 lock untouched by misses", rd_data, 8'h21);
    endtask

    task automatic t_bitop_lock();
        do_reset();
        bus_write(ADDR, 8'hA2, 1'b1, 1'b1);
        check("R5 bit-op keeps guarded bits", rd_data, 8'h80);
        bus_write(ADDR, 8'h23, 1'b1, 1'b0);
        check("R5 plain write after bit-op locked", rd_data, 8'h00);
        check_fields("R2 fields after lock");
    endtask

    task automatic t_relock();
        do_reset();
        check("R7 reset restores value", rd_data, 8'h80);
        bus_write(ADDR, 8'h22, 1'b1, 1'b0);
        check("R7 guarded writable after reset", rd_data, 8'h22);
        bus_write(ADDR, 8'h01, 1'b1, 1'b0);
        check("R8 readback after lock", rd_data, 8'h22);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_first_write();
                t_miss();
                t_bitop_lock();
                t_relock();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule